// File: doc/BRIEF.md
# Request/Acknowledge Byte Port Controller

This block is the device side of an 8-bit parallel byte port. An external chip starts each transfer by pulling an active-low request line low. The block answers on an active-low acknowledge line and moves a single byte per handshake. A configuration input sets the direction. In receive mode the byte is sampled from the data pins and handed to an internal buffer. In transmit mode a byte from the internal buffer is driven onto the pins.

Acknowledge falls before any data moves. Once acknowledge is low, the external chip may release request whenever it likes. Acknowledge rises again only when the receive sample is taken or when the transmit drive phase ends. In transmit mode the pin drivers are released on that same edge.

The internal side is a valid/ready byte interface. The pins are split into an input bus, an output bus and an output enable, so a pad ring can build the tristate buffer from them.

Top module: `rqak_port`

## Requirements
- R1: After reset, `ackN` is 1, `pinDataOe` is 0 and `rxValid` is 0.
- R2: `reqN` passes through a two-flop synchroniser. With the block idle and able to accept, `ackN` goes low on the third rising clock edge after `reqN` goes low.
- R3: In receive mode (`txMode`=0), the pins are sampled on the SAMPLE_DLY-th edge after `ackN` falls (default 2). `ackN` rises on that same edge. The sampled byte appears on `rxData`, with `rxValid` high for exactly one cycle.
- R4: `reqN` may return high at any time after `ackN` falls, and the transfer still completes normally.
- R5: A request held low produces only one transfer. A new transfer needs `reqN` to be seen high and then low again.
- R6: In receive mode, a request is not answered while `rxReady` is 0, and `ackN` stays high. Once `rxReady` is 1 the request is answered on the next edge.
- R7: In transmit mode (`txMode`=1), a request is not answered while `txValid` is 0. The byte is accepted with a one-cycle `txReady` pulse, in the cycle before `ackN` falls.
- R8: In transmit mode, `pinDataOe` rises one cycle after `ackN` falls. `pinDataOut` then carries the accepted byte for HOLD_CYC cycles (default 2).
- R9: At the end of a transmit transfer, `ackN` rises and `pinDataOe` falls on the same edge.
- R10: `pinDataOe` is 0 in receive mode and while idle, and it is only ever 1 while `ackN` is 0.
- R11: `txMode` is only taken while the block is idle. A change made during a transfer does not alter that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txMode | input | 1 | Direction: 1 transmit, 0 receive |
| reqN | input | 1 | Active-low request from the external chip (asynchronous) |
| ackN | output | 1 | Active-low acknowledge to the external chip |
| pinDataIn | input | 8 | Byte read from the data pins |
| pinDataOut | output | 8 | Byte to drive onto the data pins |
| pinDataOe | output | 1 | Output enable for the data pin drivers |
| rxData | output | 8 | Received byte toward the buffer |
| rxValid | output | 1 | One-cycle strobe marking a received byte |
| rxReady | input | 1 | Buffer can take a received byte |
| txData | input | 8 | Byte offered by the buffer |
| txValid | input | 1 | Buffer offers a byte |
| txReady | output | 1 | Byte on txData is accepted this cycle |

## Verification
The bench releases request one cycle after acknowledge falls. A design that needs request held low would then stall or abort the receive or transmit. It also keeps request low for a long time after a transfer, which exposes a level-triggered start that repeats transfers. Other tests hold back buffer readiness in each direction, and flip the direction mid-transfer. These catch a design that answers too early, drives the pins during a receive, or switches direction mid-way. Sampling and drive edges are checked cycle by cycle, so an off-by-one counter, or an output enable that outlives acknowledge, shows up as a wrong value at a known cycle.

// File: rtl/rqak_pkg.sv
package rqak_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RXWIN = 2'd1,
    ST_TXACK = 2'd2,
    ST_TXDRV = 2'd3
  } rqakState_e;

  typedef struct packed {
    logic capture;
    logic load;
    logic driveOn;
    logic driveOff;
  } rqakStrobe_t;
endpackage

// File: rtl/rqak_ctrl.sv
module rqak_ctrl
  import rqak_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_DLY  = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqNAsync,
  input  logic        txMode,
  input  logic        rxReady,
  input  logic        txValid,
  output logic        ackN,
  output logic        txReady,
  output logic        dirTx,
  output rqakStrobe_t strobe
);
  localparam int MAX_DLY = (SAMPLE_DLY > HOLD_CYC) ? SAMPLE_DLY : HOLD_CYC;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_DLY - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);

  logic [SYNC_STAGES-1:0] syncChain;
  logic reqSync;
  logic armed;
  logic canStart, startRx, startTx;
  logic [CNT_W-1:0] cnt;
  rqakState_e state;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '1;
        else       syncChain <= reqNAsync;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], reqNAsync};
    end
  endgenerate
  assign reqSync = syncChain[SYNC_STAGES-1];

  assign canStart = (state == ST_IDLE) && !reqSync && armed;
  assign startRx  = canStart && !dirTx && rxReady;
  assign startTx  = canStart && dirTx && txValid;
  assign txReady  = startTx;

  always_comb begin
    strobe          = '0;
    strobe.load     = startTx;
    strobe.capture  = (state == ST_RXWIN) && (cnt == SAMPLE_LAST);
    strobe.driveOn  = (state == ST_TXACK);
    strobe.driveOff = (state == ST_TXDRV) && (cnt == HOLD_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      ackN  <= 1'b1;
      armed <= 1'b1;
      dirTx <= 1'b0;
      cnt   <= '0;
    end else begin
      if (reqSync) armed <= 1'b1;
      else if (startRx || startTx) armed <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (startRx) begin
            state <= ST_RXWIN;
            ackN  <= 1'b0;
          end else if (startTx) begin
            state <= ST_TXACK;
            ackN  <= 1'b0;
          end else begin
            dirTx <= txMode;
          end
        end
        ST_RXWIN: begin
          if (cnt == SAMPLE_LAST) begin
            state <= ST_IDLE;
            ackN  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_TXACK: begin
          state <= ST_TXDRV;
          cnt   <= '0;
        end
        ST_TXDRV: begin
          if (cnt == HOLD_LAST) begin
            state <= ST_IDLE;
            ackN  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_idle_ack_high_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |-> ackN);
  p_rx_needs_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ackN) && !dirTx) |-> $past(rxReady));
  p_tx_needs_valid_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(ackN) && dirTx) |-> $past(txValid));
  p_dir_frozen_r11: assert property (@(posedge clk) disable iff (!rstN)
    !ackN |-> $stable(dirTx));
  p_one_start_per_req_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackN) |-> !armed);
endmodule

// File: rtl/rqak_datapath.sv
module rqak_datapath
  import rqak_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rqakStrobe_t       strobe,
  input  logic [DATA_W-1:0] pinIn,
  input  logic [DATA_W-1:0] txByte,
  output logic [DATA_W-1:0] pinOut,
  output logic              pinOe,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxStrobe
);
  logic [DATA_W-1:0] txHold;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold   <= '0;
      rxByte   <= '0;
      rxStrobe <= 1'b0;
      pinOe    <= 1'b0;
    end else begin
      rxStrobe <= strobe.capture;
      if (strobe.capture) rxByte <= pinIn;
      if (strobe.load)    txHold <= txByte;
      if (strobe.driveOn)       pinOe <= 1'b1;
      else if (strobe.driveOff) pinOe <= 1'b0;
    end
  end
  assign pinOut = txHold;

  p_rx_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxStrobe |=> !rxStrobe);
  p_oe_not_on_capture_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> !pinOe);
endmodule

// File: rtl/rqak_port.sv
module rqak_port
  import rqak_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLE_DLY  = 2,
  parameter int HOLD_CYC    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txMode,
  input  logic              reqN,
  output logic              ackN,
  input  logic [DATA_W-1:0] pinDataIn,
  output logic [DATA_W-1:0] pinDataOut,
  output logic              pinDataOe,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady
);
  rqakStrobe_t strobe;
  logic dirTx;

  rqak_ctrl #(
    .SYNC_STAGES(SYNC_STAGES),
    .SAMPLE_DLY (SAMPLE_DLY),
    .HOLD_CYC   (HOLD_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqNAsync(reqN),
    .txMode   (txMode),
    .rxReady  (rxReady),
    .txValid  (txValid),
    .ackN     (ackN),
    .txReady  (txReady),
    .dirTx    (dirTx),
    .strobe   (strobe)
  );

  rqak_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .pinIn   (pinDataIn),
    .txByte  (txData),
    .pinOut  (pinDataOut),
    .pinOe   (pinDataOe),
    .rxByte  (rxData),
    .rxStrobe(rxValid)
  );

  p_oe_with_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    pinDataOe |-> (!ackN && dirTx));
  p_release_together_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pinDataOe) |-> $rose(ackN));
  p_sample_ends_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxValid) |-> $rose(ackN));
  p_oe_after_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinDataOe) |-> $past(!ackN));
endmodule

// File: tb/rqak_port_bench.sv
module rqak_port_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic txMode = 1'b0, reqN = 1'b1, rxReady = 1'b1, txValid = 1'b0;
  logic [7:0] pinDataIn = 8'h00, txData = 8'h00;
  logic ackN, pinDataOe, rxValid, txReady;
  logic [7:0] pinDataOut, rxData;
  int checks = 0, failures = 0, cycles = 0;

  always #10 clk = ~clk;

  rqak_port u_rqak_port (
    .clk(clk), .rstN(rstN), .txMode(txMode), .reqN(reqN), .ackN(ackN),
    .pinDataIn(pinDataIn), .pinDataOut(pinDataOut), .pinDataOe(pinDataOe),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .txData(txData), .txValid(txValid), .txReady(txReady)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // receive: request released right after acknowledge falls (R4)
  task automatic rxXfer(input logic [7:0] b);
    reqN = 1'b0;
    step(2);
    chk("R2 ack still high after two edges", ackN, 1);
    step(1);
    chk("R2 ack low on third edge", ackN, 0);
    pinDataIn = b;
    reqN = 1'b1;
    step(1);
    chk("R3 ack held before sample", ackN, 0);
    chk("R10 no drive in receive", pinDataOe, 0);
    step(1);
    chk("R3 ack high at sample", ackN, 1);
    chk("R3 valid pulse", rxValid, 1);
    chk("R3 sampled byte", rxData, b);
    pinDataIn = 8'h00;
    step(1);
    chk("R3 valid one cycle", rxValid, 0);
    step(2);
  endtask

  task automatic txXfer(input logic [7:0] b);
    txValid = 1'b1;
    txData  = b;
    reqN    = 1'b0;
    step(2);
    chk("R7 ready pulse before ack", txReady, 1);
    step(1);
    chk("R2 ack low in transmit", ackN, 0);
    chk("R8 no drive on ack edge", pinDataOe, 0);
    chk("R7 ready single cycle", txReady, 0);
    txValid = 1'b0;
    txData  = 8'h00;
    reqN    = 1'b1;
    step(1);
    chk("R8 drive on", pinDataOe, 1);
    chk("R8 byte on pins", pinDataOut, b);
    step(1);
    chk("R8 still driving", pinDataOe, 1);
    chk("R8 byte held", pinDataOut, b);
    chk("R8 ack low in drive", ackN, 0);
    step(1);
    chk("R9 ack high at end", ackN, 1);
    chk("R9 drive off at end", pinDataOe, 0);
    step(2);
  endtask

  localparam logic [8:0] VEC [6] = '{
    {1'b0, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'hFF},
    {1'b1, 8'h00}, {1'b1, 8'h81}, {1'b0, 8'h5A}
  };

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    step(3);
    chk("R1 ack idle high", ackN, 1);
    chk("R1 oe off", pinDataOe, 0);
    chk("R1 valid low", rxValid, 0);
    rstN = 1'b1;
    step(2);
    chk("R1 ack high after reset", ackN, 1);

    foreach (VEC[i]) begin
      txMode = VEC[i][8];
      step(2);
      if (VEC[i][8]) txXfer(VEC[i][7:0]);
      else           rxXfer(VEC[i][7:0]);
    end

    // R5: held request gives one transfer
    txMode = 1'b0;
    step(2);
    reqN = 1'b0;
    pinDataIn = 8'h77;
    step(5);
    chk("R5 first transfer done", rxData, 8'h77);
    for (int k = 0; k < 10; k++) begin
      step(1);
      chk("R5 no second transfer", ackN, 1);
    end
    reqN = 1'b1;
    step(3);
    pinDataIn = 8'h12;
    reqN = 1'b0;
    step(3);
    chk("R5 new edge answered", ackN, 0);
    reqN = 1'b1;
    step(4);
    chk("R5 second byte", rxData, 8'h12);

    // R6: receive buffer not ready
    rxReady = 1'b0;
    reqN = 1'b0;
    pinDataIn = 8'h9C;
    for (int k = 0; k < 8; k++) begin
      step(1);
      chk("R6 unanswered while not ready", ackN, 1);
    end
    rxReady = 1'b1;
    step(1);
    chk("R6 answered once ready", ackN, 0);
    // R11: direction flip mid-transfer ignored
    txMode = 1'b1;
    reqN = 1'b1;
    step(1);
    chk("R11 still receive, no drive", pinDataOe, 0);
    step(1);
    chk("R11 receive completes", rxValid, 1);
    chk("R11 receive byte", rxData, 8'h9C);
    chk("R11 no drive after flip", pinDataOe, 0);
    step(3);

    // R7: transmit waits for valid byte
    txMode = 1'b1;
    step(2);
    reqN = 1'b0;
    for (int k = 0; k < 8; k++) begin
      step(1);
      chk("R7 unanswered without byte", ackN, 1);
      chk("R7 no ready without byte", txReady, 0);
    end
    txValid = 1'b1;
    txData = 8'hC3;
    #1;
    chk("R7 ready with byte", txReady, 1);
    step(1);
    chk("R7 answered", ackN, 0);
    txValid = 1'b0;
    txMode = 1'b0;
    reqN = 1'b1;
    step(1);
    chk("R11 transmit kept after flip", pinDataOe, 1);
    chk("R8 byte C3", pinDataOut, 8'hC3);
    step(2);
    chk("R9 end together ack", ackN, 1);
    chk("R9 end together oe", pinDataOe, 0);
    step(3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule